// File: doc/BRIEF.md
# Shift and Rotate Unit

This block moves the bits of an 8, 16 or 32-bit operand in one of eight ways: logical shifts in both directions, arithmetic shifts in both directions, plain rotates, and rotates that pass through the carry bit. The carry-through rotates treat the carry as one extra bit of the ring. Each request carries the operand, an operation code, a width code, a count source with its count register and 8-bit immediate, and the incoming carry. One clock later the unit returns the result, the new carry and the zero, sign and parity flags. It also returns two write enables that tell the flag register which flags to take.

The unit is a single registered stage. A request is taken in any cycle where `in_valid` is high. The outputs hold their values until the next request. The count is cut to its low five bits. A count that is zero after masking passes the operand through unchanged and updates no flags.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low and after it rises with no request, `out_valid`, `result`, `carry_out`, `zero_out`, `sign_out`, `parity_out`, `carry_we` and `szp_we` are all 0.
- R2: A request taken with `in_valid` high at a rising edge shows its outputs and `out_valid`=1 right after that edge. In a cycle where `in_valid` is low, `out_valid` drops and `result` and the flags keep their values.
- R3: The count is chosen by `count_src`: 0 = constant 1, 1 = `count_reg`, 2 or 3 = `count_imm`. Only bits [4:0] of the chosen value are used.
- R4: `op_sel` 4 (shift left), 6 (arithmetic shift left) and 5 (logical shift right) fill the vacated bits with zeros. `carry_out` is the last bit shifted out. A count at or above the width gives 0, and the carry is then 0 unless the count equals the width.
- R5: `op_sel` 7 (arithmetic shift right) fills with copies of the operand's sign bit (bit width-1). A count at or above the width gives all sign bits, with carry equal to the sign.
- R6: `op_sel` 0 (rotate left) and 1 (rotate right) rotate within the width. `carry_out` is the new bit 0 after a left rotate and the new bit width-1 after a right rotate.
- R7: `op_sel` 2 (rotate left through carry) and 3 (rotate right through carry) rotate a ring of width+1 bits, with `carry_in` above bit width-1. The effective count is the masked count modulo width+1, and `carry_out` is the ring's top bit afterwards.
- R8: `width_sel` 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand bits above the width are ignored, and `result` bits above the width are 0.
- R9: A masked count of 0 gives `result` = operand within the width and `carry_out` = `carry_in`, with `carry_we` and `szp_we` both low.
- R10: `zero_out` is 1 when the result within the width is 0. `sign_out` is result bit width-1. `parity_out` is 1 when `result[7:0]` holds an even number of ones. With a nonzero masked count, `carry_we` is 1 for all operations and `szp_we` is 1 only for the shifts (`op_sel` 4 to 7). Both enables are 0 when `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code |
| width_sel | input | 2 | Operand width code |
| count_src | input | 2 | Count source select |
| count_reg | input | 8 | Count register value |
| count_imm | input | 8 | Immediate count |
| operand | input | 32 | Value to shift or rotate |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Outputs belong to a request taken at the last edge |
| result | output | 32 | Shifted or rotated value, zero above the width |
| carry_out | output | 1 | New carry flag |
| zero_out | output | 1 | Result is zero |
| sign_out | output | 1 | Top bit of the result within the width |
| parity_out | output | 1 | Even parity of the result's low byte |
| carry_we | output | 1 | Carry flag should be written |
| szp_we | output | 1 | Zero, sign and parity flags should be written |

## Verification
The only state in this block is the single output register. An error there shows up on the outputs in the cycle right after the request, or as a value that fails to hold on an idle cycle. The harder faults are in the count and ring arithmetic. A wrong modulo for the carry-through rotates, or a wrong carry-bit index at counts equal to or above the width, gives a wrong result or carry only for those counts. For that reason the random requests draw counts from the full five-bit range at every width, and directed requests cover counts 0, 1, width and width+1.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op_sel,
  input  logic [1:0]  width_sel,
  input  logic [1:0]  count_src,
  input  logic [7:0]  count_reg,
  input  logic [7:0]  count_imm,
  input  logic [31:0] operand,
  input  logic        carry_in,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        carry_out,
  output logic        zero_out,
  output logic        sign_out,
  output logic        parity_out,
  output logic        carry_we,
  output logic        szp_we
);

  localparam int XLEN = 32;
  localparam int DLEN = 2 * XLEN;

  logic [6:0]      w;
  logic [6:0]      w1;
  logic [XLEN-1:0] mask;
  logic [7:0]      raw_cnt;
  logic [4:0]      cnt;
  logic [4:0]      rot_n;
  logic [5:0]      rc_n;
  logic [XLEN-1:0] opm;
  logic            sgn;

  always_comb begin
    case (width_sel)
      2'd0:    begin w = 7'd8;  mask = 32'h0000_00FF; end
      2'd1:    begin w = 7'd16; mask = 32'h0000_FFFF; end
      default: begin w = 7'd32; mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign w1  = w + 7'd1;
  assign opm = operand & mask;
  assign sgn = opm[w[5:0] - 6'd1];

  always_comb begin
    case (count_src)
      2'd0:    raw_cnt = 8'd1;
      2'd1:    raw_cnt = count_reg;
      default: raw_cnt = count_imm;
    endcase
  end

  assign cnt   = raw_cnt[4:0];
  assign rot_n = cnt & 5'(w - 7'd1);

  always_comb begin
    case (width_sel)
      2'd0:    rc_n = 6'({1'b0, cnt} % 6'd9);
      2'd1:    rc_n = 6'({1'b0, cnt} % 6'd17);
      default: rc_n = {1'b0, cnt};
    endcase
  end

  // wide views of the operand for the shift network
  logic [DLEN-1:0] zx, sx, ring, ring_mask;
  logic [DLEN:0]   shl_v, shr_v, sar_v;
  logic [DLEN-1:0] rol_v, ror_v, rcl_v, rcr_v;

  assign zx        = {32'd0, opm};
  assign sx        = {{32{sgn}}, opm | (sgn ? ~mask : 32'd0)};
  assign ring      = zx | (64'(carry_in) << w);
  assign ring_mask = ({32'd0, mask} << 1) | 64'd1;

  assign shl_v = {1'b0, zx} << cnt;
  assign shr_v = {zx, 1'b0} >> cnt;
  assign sar_v = {sx, 1'b0} >> cnt;

  assign rol_v = (zx << rot_n) | (zx >> (w - 7'(rot_n)));
  assign ror_v = (zx >> rot_n) | (zx << (w - 7'(rot_n)));
  assign rcl_v = ((ring << rc_n) | (ring >> (w1 - 7'(rc_n)))) & ring_mask;
  assign rcr_v = ((ring >> rc_n) | (ring << (w1 - 7'(rc_n)))) & ring_mask;

  logic [XLEN-1:0] nres;
  logic            ncar;

  always_comb begin
    nres = opm;
    ncar = carry_in;
    if (cnt != 5'd0) begin
      case (op_sel)
        3'd0: begin nres = rol_v[XLEN-1:0] & mask; ncar = rol_v[0]; end
        3'd1: begin nres = ror_v[XLEN-1:0] & mask; ncar = ror_v[w[5:0] - 6'd1]; end
        3'd2: begin nres = rcl_v[XLEN-1:0] & mask; ncar = rcl_v[w[5:0]]; end
        3'd3: begin nres = rcr_v[XLEN-1:0] & mask; ncar = rcr_v[w[5:0]]; end
        3'd5: begin nres = shr_v[XLEN:1] & mask;   ncar = shr_v[0]; end
        3'd7: begin nres = sar_v[XLEN:1] & mask;   ncar = sar_v[0]; end
        default: begin nres = shl_v[XLEN-1:0] & mask; ncar = shl_v[w[5:0]]; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      carry_out  <= 1'b0;
      zero_out   <= 1'b0;
      sign_out   <= 1'b0;
      parity_out <= 1'b0;
      carry_we   <= 1'b0;
      szp_we     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      carry_we  <= in_valid && (cnt != 5'd0);
      szp_we    <= in_valid && (cnt != 5'd0) && op_sel[2];
      if (in_valid) begin
        result     <= nres;
        carry_out  <= ncar;
        zero_out   <= (nres == '0);
        sign_out   <= nres[w[5:0] - 6'd1];
        parity_out <= ~^nres[7:0];
      end
    end
  end

endmodule

// File: rtl/shift_rotate_unit_checks.sv
module shift_rotate_unit_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op_sel,
  input logic [1:0]  width_sel,
  input logic        carry_in,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        carry_out,
  input logic        carry_we,
  input logic        szp_we
);

  AST_VALID_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && !out_valid); // R2

  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !carry_we && !szp_we); // R10

  AST_ROT_NO_SZP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(op_sel[2]) |-> !szp_we); // R10

  AST_ZERO_CNT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !carry_we |-> carry_out == $past(carry_in) && !szp_we); // R9

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(width_sel) == 2'd0 |-> result[31:8] == 24'd0); // R8

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(width_sel) == 2'd1 |-> result[31:16] == 16'd0); // R8

endmodule

bind shift_rotate_unit shift_rotate_unit_checks u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .width_sel(width_sel), .carry_in(carry_in), .out_valid(out_valid),
  .result(result), .carry_out(carry_out), .carry_we(carry_we), .szp_we(szp_we)
);

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  width_sel = '0;
  logic [1:0]  count_src = '0;
  logic [7:0]  count_reg = '0;
  logic [7:0]  count_imm = '0;
  logic [31:0] operand = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, carry_out, zero_out, sign_out, parity_out, carry_we, szp_we;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  shift_rotate_unit u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .width_sel(width_sel), .count_src(count_src), .count_reg(count_reg),
    .count_imm(count_imm), .operand(operand), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .zero_out(zero_out), .sign_out(sign_out), .parity_out(parity_out),
    .carry_we(carry_we), .szp_we(szp_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] ws);
    return (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
  endfunction

  // bit-serial model: one position per step
  function automatic void model(input logic [2:0] op, input int w, input int n,
                                input logic [31:0] a, input logic cin,
                                output logic [31:0] r, output logic c);
    logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    logic [31:0] v = a & m;
    logic b;
    c = cin;
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0: begin b = v[w-1]; v = (v << 1) | 32'(b); c = b; end
        3'd1: begin b = v[0];   v = (v >> 1) | (32'(b) << (w-1)); c = b; end
        3'd2: begin b = v[w-1]; v = (v << 1) | 32'(c); c = b; end
        3'd3: begin b = v[0];   v = (v >> 1) | (32'(c) << (w-1)); c = b; end
        3'd5: begin c = v[0];   v = v >> 1; end
        3'd7: begin c = v[0];   v = (v >> 1) | (32'(v[w-1]) << (w-1)); end
        default: begin c = v[w-1]; v = v << 1; end
      endcase
      v = v & m;
    end
    r = v;
  endfunction

  task automatic run(input logic [2:0] op, input logic [1:0] ws, input logic [1:0] src,
                     input logic [7:0] creg, input logic [7:0] imm,
                     input logic [31:0] a, input logic cin);
    int w = width_of(ws);
    logic [7:0] raw = (src == 2'd0) ? 8'd1 : (src == 2'd1) ? creg : imm;
    int n = int'(raw[4:0]);
    logic [31:0] er;
    logic ec;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; width_sel = ws; count_src = src;
    count_reg = creg; count_imm = imm; operand = a; carry_in = cin;
    @(negedge clk);
    in_valid = 1'b0;
    model(op, w, n, a, cin, er, ec);
    check(n == 0 ? "R9 result" : (op >= 3'd4 ? (op == 3'd7 ? "R5 result" : "R4 result")
          : (op >= 3'd2 ? "R7 result" : "R6 result")), result, er);
    check(n == 0 ? "R9 carry" : "R3 R4 R5 R6 R7 carry", 32'(carry_out), 32'(ec));
    check("R10 zero", 32'(zero_out), 32'(er == 32'd0));
    check("R10 sign", 32'(sign_out), 32'(er[w-1]));
    check("R10 parity", 32'(parity_out), 32'(~^er[7:0]));
    check("R10 carry_we", 32'(carry_we), 32'(n != 0));
    check("R10 szp_we", 32'(szp_we), 32'(n != 0 && op[2]));
    check("R2 out_valid", 32'(out_valid), 32'd1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {carry_out, zero_out, sign_out, parity_out, carry_we, szp_we}, 32'd0);

    // directed examples (op codes: 5 SHR, 7 SAR, 0 ROL, 2 RCL)
    run(3'd5, 2'd0, 2'd0, 8'd0, 8'd0, 32'hB7, 1'b0);
    check("R4 literal", result, 32'h5B); check("R4 carry literal", 32'(carry_out), 32'd1);
    run(3'd5, 2'd0, 2'd1, 8'd3, 8'd0, 32'h5B, 1'b1);
    check("R4 literal", result, 32'h0B); check("R4 carry literal", 32'(carry_out), 32'd0);
    run(3'd7, 2'd0, 2'd0, 8'd0, 8'd0, 32'hB7, 1'b0); check("R5 literal", result, 32'hDB);
    run(3'd7, 2'd0, 2'd2, 8'd0, 8'd3, 32'hDB, 1'b0); check("R5 literal", result, 32'hFB);
    run(3'd0, 2'd0, 2'd0, 8'd0, 8'd0, 32'hB7, 1'b0); check("R6 literal", result, 32'h6F);
    run(3'd0, 2'd0, 2'd3, 8'd0, 8'd3, 32'h6F, 1'b0); check("R6 literal", result, 32'h7B);
    run(3'd2, 2'd0, 2'd0, 8'd0, 8'd0, 32'hB7, 1'b0);
    check("R7 literal", result, 32'h6E); check("R7 carry literal", 32'(carry_out), 32'd1);
    // count masking: 0x28 -> 8 (R3), 0x20 -> 0 (R9)
    run(3'd4, 2'd0, 2'd1, 8'h28, 8'd0, 32'h81, 1'b0);
    check("R3 masked count", result, 32'd0); check("R3 carry", 32'(carry_out), 32'd1);
    run(3'd4, 2'd1, 2'd2, 8'd0, 8'h20, 32'hFFFF_1234, 1'b1);
    check("R9 passthrough", result, 32'h1234); check("R8 upper", result[31:16], 32'd0);
    // boundary counts at each width
    run(3'd7, 2'd1, 2'd2, 8'd0, 8'd16, 32'h8000, 1'b0); check("R5 all sign", result, 32'hFFFF);
    run(3'd5, 2'd2, 2'd2, 8'd0, 8'd31, 32'h8000_0000, 1'b0); check("R4 far", result, 32'd1);
    run(3'd3, 2'd0, 2'd2, 8'd0, 8'd9, 32'hA5, 1'b1); check("R7 full ring", result, 32'hA5);
    run(3'd2, 2'd1, 2'd2, 8'd0, 8'd17, 32'h1234, 1'b0); check("R7 full ring", result, 32'h1234);
    run(3'd1, 2'd3, 2'd2, 8'd0, 8'd1, 32'h1, 1'b0); check("R8 width code 3", result, 32'h8000_0000);

    // hold on idle cycle
    held = result;
    @(negedge clk);
    operand = 32'hDEAD_BEEF; op_sel = 3'd4;
    @(negedge clk);
    check("R2 hold", result, held);
    check("R2 idle valid", 32'(out_valid), 32'd0);

    for (int k = 0; k < 400; k++) begin
      run(3'($urandom), 2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
          $urandom, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule